// File: doc/BRIEF.md
# Edge-Triggered Interrupt Scheduler Control Word

This block is a single memory-mapped control word that schedules interrupts for a processor. Devices drive plain request lines into it. It samples those lines on the shared clock, turns each rising edge into a latched pending flag and, when the processor is in normal state, moves the processor into interrupt state. Because requests are captured on edges, a device never has to be accessed to withdraw a request. Each device keeps its own interrupt status and configuration. This block only decides when an interrupt is taken.

The control word holds two writable bits. The active bit shows that the processor is in interrupt state. While it is set, the processor runs from its alternate program counter and condition-code bank. Writing the active bit to zero ends the handler. Writing the software-request bit to one asks for an interrupt without any device, and that bit clears itself when the interrupt is taken. The bus interface acknowledges a request in the same cycle it is presented.

Top module: `irq_sched`

## Requirements
- R1: After reset, the active bit, the software-request bit, the pending flag and `int_enter` are all zero.
- R2: A low-to-high change on any `irq_lines` bit between two consecutive clock edges sets the pending flag (read word bit 2) after the second edge. A line held high produces only one such event, and a falling edge produces none. A line that is already high when reset is released produces no event.
- R3: When the active bit is 0, no bus write is in progress, and either the pending flag or the software-request bit is set, the block takes an interrupt on the next edge. At that edge the active bit becomes 1, `int_enter` is high for exactly that one cycle, and every latched pending edge is cleared.
- R4: Edges that arrive while the active bit is 1 stay pending and cause no new entry. They are taken on the first edge after the active bit returns to 0.
- R5: A bus write loads the active bit from `bus_wdata[0]`. Writing 0 returns the processor to normal state. Without a write, the active bit stays set.
- R6: A bus write loads the software-request bit from `bus_wdata[1]`. A 1 written while the active bit is 0 causes an interrupt entry one edge later, and that entry clears the software-request bit.
- R7: `bus_rdata` presents the active bit in bit 0, the software-request bit in bit 1 and the pending flag in bit 2. All higher bits read as zero.
- R8: `bus_ack` is high in the same cycle as `bus_sel`, so every access completes on the edge where it first appears.
- R9: A bus write on the edge where an entry would otherwise be taken holds the entry back, and the write alone decides the new bit values.
- R10: An edge that arrives on the same clock edge that takes an interrupt stays pending after the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_SRC | Request lines from devices, edge sampled |
| bus_sel | input | 1 | Access to the control word this cycle |
| bus_we | input | 1 | Access is a write |
| bus_wdata | input | DATA_W | Write data; bit 0 active, bit 1 software request |
| bus_rdata | output | DATA_W | Control word read value |
| bus_ack | output | 1 | Same-cycle acknowledge |
| int_state | output | 1 | Processor in interrupt state (alternate PC and condition bank) |
| int_enter | output | 1 | One-cycle pulse on interrupt entry |

## Verification
A wrong edge detector or a wrong pending latch shows at bit 2 of the read word one clock after the offending edge. It also shows as a missing or extra `int_enter` pulse on the following edge. A bad entry or write priority decision shows on `int_state` and the software-request bit within a single cycle. The bench's cycle model catches such faults on the first clock where the outputs diverge. Directed sequences drive the corner orderings: an edge during a handler, an edge in the entry cycle, and a write that collides with an entry.

// File: rtl/irq_sched_pkg.sv
package irq_sched_pkg;
   // Field positions inside the control word; software decodes these.
   localparam int unsigned BIT_ACT  = 0;
   localparam int unsigned BIT_SWQ  = 1;
   localparam int unsigned BIT_PEND = 2;
   localparam int unsigned CTL_BITS = 3;

   typedef struct packed {
      logic pend;
      logic swq;
      logic act;
   } ctl_word_t;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
   parameter int unsigned NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] lines,
   input  logic               take,
   output logic               pend_any
);
   logic [NUM_SRC-1:0] rise;
   logic [NUM_SRC-1:0] pend_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic prev_q;
      // Reset to high so a line already asserted at release makes no edge.
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= lines[g];
      end
      assign rise[g] = lines[g] & ~prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[g] <= 1'b0;
         else        pend_q[g] <= (pend_q[g] & ~take) | rise[g];
      end
   end

   assign pend_any = |pend_q;

   assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> pend_any);
endmodule

// File: rtl/irq_ctl_word.sv
module irq_ctl_word (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_act,
   input  logic wr_swq,
   input  logic pend_any,
   output logic act,
   output logic swq,
   output logic take,
   output logic enter
);
   logic act_q, swq_q, enter_q;

   // A bus write owns the cycle; an entry waits one more edge.
   assign take = ~act_q & (pend_any | swq_q) & ~wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         swq_q   <= 1'b0;
         enter_q <= 1'b0;
      end else begin
         enter_q <= take;
         if (wr) begin
            act_q <= wr_act;
            swq_q <= wr_swq;
         end else if (take) begin
            act_q <= 1'b1;
            swq_q <= 1'b0;
         end
      end
   end

   assign act   = act_q;
   assign swq   = swq_q;
   assign enter = enter_q;

   assert_enter_sets_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      enter |-> act);
   assert_swq_cleared_on_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      enter |-> !swq);
   assert_active_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !wr) |=> act);
endmodule

// File: rtl/irq_sched.sv
module irq_sched #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned DATA_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_lines,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_ack,
   output logic               int_state,
   output logic               int_enter
);
   import irq_sched_pkg::*;

   localparam int unsigned PAD_W = DATA_W - CTL_BITS;

   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_sched: NUM_SRC must be at least 1");
   end
   if (DATA_W <= CTL_BITS) begin : g_bad_w
      $error("irq_sched: DATA_W must exceed the control field width");
   end

   logic      wr, take, pend_any, act, swq;
   ctl_word_t word;

   assign wr = bus_sel & bus_we;

   irq_edge_capture #(.NUM_SRC(NUM_SRC)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .lines    (irq_lines),
      .take     (take),
      .pend_any (pend_any)
   );

   irq_ctl_word ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr),
      .wr_act   (bus_wdata[BIT_ACT]),
      .wr_swq   (bus_wdata[BIT_SWQ]),
      .pend_any (pend_any),
      .act      (act),
      .swq      (swq),
      .take     (take),
      .enter    (int_enter)
   );

   assign word      = '{pend: pend_any, swq: swq, act: act};
   assign bus_rdata = {{PAD_W{1'b0}}, word};
   assign bus_ack   = bus_sel;
   assign int_state = act;

   assert_entry_from_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_enter) |-> $rose(int_state));
endmodule

// File: tb/irq_sched_tb_top.sv
module irq_sched_tb_top;
   localparam int N = 4;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] lines = '1;
   logic         sel = 1'b0, we = 1'b0;
   logic [W-1:0] wd = '0;
   logic [W-1:0] rd;
   logic         ack, st, ent;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   // Reference state
   logic [N-1:0] m_prev, m_pend;
   logic         m_act, m_swq, m_ent;

   always #5 clk = ~clk;

   irq_sched #(.NUM_SRC(N), .DATA_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_sel(sel), .bus_we(we),
      .bus_wdata(wd), .bus_rdata(rd), .bus_ack(ack), .int_state(st), .int_enter(ent)
   );

   task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   // Behavioural model, advanced on every rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_prev = '1; m_pend = '0; m_act = 0; m_swq = 0; m_ent = 0;
      end else begin
         logic [N-1:0] rise;
         bit w, tk;
         rise = lines & ~m_prev;
         w    = sel && we;
         tk   = !m_act && (m_pend != 0 || m_swq) && !w;
         if (w) begin m_act = wd[0]; m_swq = wd[1]; end
         else if (tk) begin m_act = 1; m_swq = 0; end
         m_pend = (tk ? '0 : m_pend) | rise;
         m_ent  = tk;
         m_prev = lines;
      end
   end

   task automatic compare();
      logic [W-1:0] exp_rd;
      exp_rd = {13'd0, (m_pend != 0), m_swq, m_act};
      chk(st == m_act,         "R3/R5 int_state",     st, m_act);
      chk(ent == m_ent,        "R3 int_enter",        ent, m_ent);
      chk(rd[1] == m_swq,      "R6 swq bit",          rd[1], m_swq);
      chk(rd[2] == (m_pend!=0),"R2 pending bit",      rd[2], m_pend != 0);
      chk(rd == exp_rd,        "R7 read word",        rd, exp_rd);
      chk(ack == sel,          "R8 same-cycle ack",   ack, sel);
   endtask

   task automatic step(input logic [N-1:0] l, input bit s, input bit w, input logic [W-1:0] d);
      lines = l; sel = s; we = w; wd = d;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle(); step(lines, 0, 0, '0); endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state, line 0 held high through reset
      lines = 4'b0001;
      @(negedge clk);
      rst_n = 1;
      chk(st == 0 && ent == 0 && rd == 0, "R1 reset state", rd, 0);
      idle();
      chk(rd[2] == 0, "R2 high at reset gives no edge", rd[2], 0);
      idle();
      // R2/R3: rising edge on line 1, entry next edge
      step(4'b0011, 0, 0, '0);
      chk(rd[2] == 1 && st == 0, "R2 edge latched", rd, 4);
      idle();
      chk(st == 1 && ent == 1 && rd[2] == 0, "R3 entry clears pending", rd, 1);
      idle();
      chk(ent == 0 && st == 1, "R3 enter is one cycle", ent, 0);
      // R4: edge during handler stays pending
      step(4'b0111, 0, 0, '0);
      idle();
      chk(st == 1 && rd[2] == 1 && ent == 0, "R4 edge held while active", rd, 5);
      step(4'b0011, 0, 0, '0);   // falling edge: nothing new
      step(lines, 1, 1, 16'h0000);
      chk(st == 0 && rd[2] == 1, "R5 write clears active", rd, 4);
      idle();
      chk(st == 1 && ent == 1, "R4 held edge taken after exit", ent, 1);
      step(lines, 1, 1, 16'h0000);
      idle();
      chk(st == 0 && ent == 0, "R5 exit with nothing pending", st, 0);
      // R6: software request
      step(lines, 1, 1, 16'h0002);
      chk(rd[1] == 1 && st == 0, "R6 swq written", rd, 2);
      idle();
      chk(st == 1 && ent == 1 && rd[1] == 0, "R6 swq cleared on entry", rd, 1);
      step(lines, 1, 1, 16'h0000);
      // R9: write collides with entry condition
      step(4'b1011, 0, 0, '0);
      step(lines, 1, 1, 16'h0000);
      chk(st == 0 && rd[2] == 1 && ent == 0, "R9 write defers entry", rd, 4);
      idle();
      chk(st == 1 && ent == 1, "R9 entry after write", st, 1);
      step(lines, 1, 1, 16'h0000);
      // R10: edge in the entry cycle survives
      step(4'b0000, 0, 0, '0);
      step(4'b0100, 0, 0, '0);  // edge latched
      step(4'b0110, 0, 0, '0);  // entry edge + new edge on line 1
      chk(st == 1 && ent == 1 && rd[2] == 1, "R10 edge in entry cycle kept", rd, 5);
      step(lines, 1, 1, 16'h0000);
      idle();
      chk(ent == 1, "R10 kept edge taken", ent, 1);
      // R7: upper write bits do not appear
      step(lines, 1, 1, 16'hFFF9);
      chk(rd[W-1:3] == 0, "R7 upper bits zero", rd, rd & 7);
      step(lines, 1, 1, 16'h0000);
      repeat (4) idle();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule